// File: doc/BRIEF.md
# Oversampled Serial Receiver with Trigger-Level FIFO

This block receives asynchronous serial frames: a start bit, eight data bits sent least significant first, an optional parity bit and one stop bit. The input line passes through a two-flop synchroniser. It is then examined only on clock cycles where the sixteen-times-bit-rate enable `tick16` is high. The receiver locks its bit timing to the falling edge of each start bit and takes every bit at its centre. Completed bytes go into a sixteen-entry receive FIFO. Software drains the FIFO through a pop strobe and a head-of-queue data output.

A data-ready flag rises when the FIFO occupancy reaches a programmed trigger level. The flag is level-conditioned: a clear strobe only takes effect while the occupancy is below the trigger. Framing, parity and overrun errors are kept as sticky flags. A line held low for a whole frame is treated as a break. While the break lasts, reception keeps running but nothing is written to the FIFO. The synchronised line level is brought out so that software can confirm a break after a framing error.

Top module: `uart_rx_trig`

## Requirements
- R1: After reset, `rx_count` is 0 and `full_flag`, `fer_flag`, `per_flag`, `ovr_flag` and `brk_active` are all 0.
- R2: A start bit is detected on a tick where the synchronised line is low and was high at the previous tick. That tick is phase 0, and each bit is sampled on the tick whose phase is 8 (mod 16). If the start bit samples high at its centre, the frame is abandoned and nothing is written.
- R3: The eight data bits arrive least significant bit first. A completed frame writes its byte into the FIFO, and the FIFO holds it at the tail.
- R4: With `par_en`=1, the parity bit follows the data. Even parity is used when `par_odd`=0 and odd parity when `par_odd`=1. A mismatch sets sticky `per_flag`.
- R5: A stop bit sampled low sets sticky `fer_flag`, and the byte is still written unless the frame is a break. `err_clr` clears `fer_flag`, `per_flag` and `ovr_flag`.
- R6: `rd_data` shows the oldest byte. A cycle with `rd_en`=1 and a non-empty FIFO removes that byte. `rd_en` on an empty FIFO leaves the count at 0.
- R7: `rx_count` equals the number of bytes held, zero-extended to 8 bits, and never exceeds 16.
- R8: `full_flag` becomes 1 in the cycle after `rx_count` >= `trig_lvl`. It then stays 1 until `full_clr` is applied while `rx_count` < `trig_lvl`.
- R9: `full_clr` applied while `rx_count` >= `trig_lvl` has no effect: `full_flag` reads 1 in the next cycle.
- R10: A completed byte that arrives while 16 bytes are held and no pop happens in the same cycle is discarded, and it sets sticky `ovr_flag`.
- R11: A completed byte that arrives in the same cycle as a pop on a full FIFO is stored. The count stays 16 and `ovr_flag` is not set.
- R12: A break frame has all-zero data, a zero parity bit when parity is enabled, and a low stop bit. Such a frame sets `fer_flag` and `brk_active` and is not written. While `brk_active` is 1, no completed frame is written.
- R13: `brk_active` returns to 0 after the line has been sampled high on 16 consecutive ticks. Frames completed after that are written again.
- R14: `rx_pin` equals `rx_in` delayed by two clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick16 | input | 1 | Enable at sixteen times the bit rate |
| rx_in | input | 1 | Serial receive line |
| par_en | input | 1 | Expect a parity bit after the data |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| trig_lvl | input | 8 | Occupancy at which `full_flag` rises |
| rd_en | input | 1 | Pop the oldest byte |
| rd_data | output | 8 | Oldest byte in the FIFO |
| rx_count | output | 8 | FIFO occupancy |
| full_clr | input | 1 | Request to lower `full_flag` |
| full_flag | output | 1 | Occupancy reached the trigger level |
| err_clr | input | 1 | Clear the sticky error flags |
| fer_flag | output | 1 | Framing error seen |
| per_flag | output | 1 | Parity error seen |
| ovr_flag | output | 1 | Byte discarded on a full FIFO |
| brk_active | output | 1 | Break in progress, writes suppressed |
| rx_pin | output | 1 | Synchronised line level |

## Verification
Two pairs of functions can coincide. The first is a byte completing in the same cycle that software pops a full FIFO. The bench provokes it by raising `rd_en` exactly in the cycle its own model announces a write. It then judges that the count stays at 16 and that no overrun is flagged. The second is a flag-clear strobe while the occupancy sits at or above the trigger, where `full_flag` must hold at 1. The same strobe must lower the flag once a read has taken the count below the trigger. A behavioural model of the line, the FIFO queue and every flag is compared with the outputs on every clock.

// File: rtl/urx_pkg.sv
package urx_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_phase_e;

  typedef struct packed {
    logic              push;
    logic              fer;
    logic              per;
    logic [DATA_W-1:0] data;
  } rx_evt_t;

endpackage

// File: rtl/urx_rst_sync.sv
module urx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b1;
          else        stage_q[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b1;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/urx_frame.sv
module urx_frame
  import urx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    rx_s,
  input  logic    par_en,
  input  logic    par_odd,
  output rx_evt_t evt,
  output logic    brk
);
  localparam int PH_W  = $clog2(OSR);
  localparam int HI_W  = $clog2(OSR + 1);
  localparam int BIT_W = $clog2(DATA_W);

  rx_phase_e         st_q, st_n;
  logic [PH_W-1:0]   ph_q, ph_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              pacc_q, pacc_n;
  logic              pbit_q, pbit_n;
  logic              pbad_q, pbad_n;
  logic              last_q, last_n;
  logic              brk_q, brk_n;
  logic [HI_W-1:0]   hi_q, hi_n;
  rx_evt_t           evt_q, evt_n;
  logic              centre;
  logic              is_break;

  assign centre   = (ph_q == PH_W'(OSR/2 - 1));
  assign is_break = !rx_s && (sh_q == '0) && (!par_en || !pbit_q);

  always_comb begin
    st_n   = st_q;
    ph_n   = ph_q;
    bit_n  = bit_q;
    sh_n   = sh_q;
    pacc_n = pacc_q;
    pbit_n = pbit_q;
    pbad_n = pbad_q;
    last_n = last_q;
    brk_n  = brk_q;
    hi_n   = hi_q;
    evt_n  = '0;
    if (tick) begin
      last_n = rx_s;
      if (rx_s) begin
        if (hi_q != HI_W'(OSR)) hi_n = hi_q + HI_W'(1);
      end else begin
        hi_n = '0;
      end
      if (brk_q && rx_s && (hi_q == HI_W'(OSR - 1))) brk_n = 1'b0;
      if (st_q == RX_IDLE) begin
        if (last_q && !rx_s) begin
          st_n = RX_START;
          ph_n = '0;
        end
      end else begin
        ph_n = ph_q + PH_W'(1);
        if (centre) begin
          unique case (st_q)
            RX_START: begin
              if (rx_s) begin
                st_n = RX_IDLE;
              end else begin
                st_n   = RX_DATA;
                bit_n  = '0;
                pacc_n = 1'b0;
                pbit_n = 1'b0;
              end
            end
            RX_DATA: begin
              sh_n   = {rx_s, sh_q[DATA_W-1:1]};
              pacc_n = pacc_q ^ rx_s;
              bit_n  = bit_q + BIT_W'(1);
              if (bit_q == BIT_W'(DATA_W - 1)) st_n = par_en ? RX_PAR : RX_STOP;
            end
            RX_PAR: begin
              pbit_n = rx_s;
              pbad_n = rx_s ^ pacc_q ^ par_odd;
              st_n   = RX_STOP;
            end
            RX_STOP: begin
              st_n       = RX_IDLE;
              evt_n.fer  = !rx_s;
              evt_n.per  = par_en && pbad_q;
              evt_n.push = !brk_q && !is_break;
              evt_n.data = sh_q;
              if (is_break) brk_n = 1'b1;
            end
            default: st_n = RX_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      ph_q   <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      pacc_q <= 1'b0;
      pbit_q <= 1'b0;
      pbad_q <= 1'b0;
      last_q <= 1'b1;
      brk_q  <= 1'b0;
      hi_q   <= '0;
      evt_q  <= '0;
    end else begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      pacc_q <= pacc_n;
      pbit_q <= pbit_n;
      pbad_q <= pbad_n;
      last_q <= last_n;
      brk_q  <= brk_n;
      hi_q   <= hi_n;
      evt_q  <= evt_n;
    end
  end

  assign evt = evt_q;
  assign brk = brk_q;
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop_req,
  output logic [DW-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       drop
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_n;
  logic [AW-1:0] rptr_q, rptr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          pop, accept;

  assign pop    = pop_req && (cnt_q != '0);
  assign accept = push && ((cnt_q != CW'(DEPTH)) || pop);
  assign drop   = push && !accept;

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (accept) wptr_n = wptr_q + AW'(1);
    if (pop)    rptr_n = rptr_q + AW'(1);
    if (accept && !pop)      cnt_n = cnt_q + CW'(1);
    else if (pop && !accept) cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wptr_q] <= push_data;
  end

  assign head  = mem[rptr_q];
  assign count = cnt_q;
endmodule

// File: rtl/uart_rx_trig.sv
module uart_rx_trig
  import urx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int OSR         = 16,
  parameter int CNT_OUT_W   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick16,
  input  logic                 rx_in,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic [CNT_OUT_W-1:0] trig_lvl,
  input  logic                 rd_en,
  output logic [DATA_W-1:0]    rd_data,
  output logic [CNT_OUT_W-1:0] rx_count,
  input  logic                 full_clr,
  output logic                 full_flag,
  input  logic                 err_clr,
  output logic                 fer_flag,
  output logic                 per_flag,
  output logic                 ovr_flag,
  output logic                 brk_active,
  output logic                 rx_pin
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          srst_n;
  logic          rx_s;
  rx_evt_t       evt;
  logic          brk;
  logic [CW-1:0] fifo_cnt;
  logic          drop;
  logic          full_q, full_n;
  logic          fer_q, fer_n;
  logic          per_q, per_n;
  logic          ovr_q, ovr_n;

  urx_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .din   (rx_in),
    .dout  (rx_s)
  );

  urx_frame #(.OSR(OSR)) u_frame (
    .clk     (clk),
    .rst_n   (srst_n),
    .tick    (tick16),
    .rx_s    (rx_s),
    .par_en  (par_en),
    .par_odd (par_odd),
    .evt     (evt),
    .brk     (brk)
  );

  urx_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (srst_n),
    .push      (evt.push),
    .push_data (evt.data),
    .pop_req   (rd_en),
    .head      (rd_data),
    .count     (fifo_cnt),
    .drop      (drop)
  );

  always_comb begin
    full_n = (CNT_OUT_W'(fifo_cnt) >= trig_lvl) || (full_q && !full_clr);
    fer_n  = evt.fer || (fer_q && !err_clr);
    per_n  = evt.per || (per_q && !err_clr);
    ovr_n  = drop    || (ovr_q && !err_clr);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      full_q <= 1'b0;
      fer_q  <= 1'b0;
      per_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      full_q <= full_n;
      fer_q  <= fer_n;
      per_q  <= per_n;
      ovr_q  <= ovr_n;
    end
  end

  assign rx_count   = CNT_OUT_W'(fifo_cnt);
  assign full_flag  = full_q;
  assign fer_flag   = fer_q;
  assign per_flag   = per_q;
  assign ovr_flag   = ovr_q;
  assign brk_active = brk;
  assign rx_pin     = rx_s;
endmodule

// File: rtl/uart_rx_trig_chk.sv
module uart_rx_trig_chk #(
  parameter int DEPTH     = 16,
  parameter int CNT_OUT_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_in,
  input logic                 rx_pin,
  input logic [CNT_OUT_W-1:0] rx_count,
  input logic [CNT_OUT_W-1:0] trig_lvl,
  input logic                 full_flag,
  input logic                 full_clr,
  input logic                 ovr_flag,
  input logic                 brk_active
);
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_OUT_W'(DEPTH));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == $past(rx_count)) || (rx_count == $past(rx_count) + 1'b1) ||
    (rx_count == $past(rx_count) - 1'b1));

  assert_full_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count >= trig_lvl) |=> full_flag);

  assert_clear_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_clr && rx_count >= trig_lvl) |=> full_flag);

  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_clr && rx_count < trig_lvl) |=> !full_flag);

  assert_ovr_on_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> ($past(rx_count) == CNT_OUT_W'(DEPTH)));

  assert_no_write_in_break_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count > $past(rx_count)) |-> !$past(brk_active, 2));

  assert_pin_delay_R14: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pin == $past(rx_in, 2));
endmodule

bind uart_rx_trig uart_rx_trig_chk #(.DEPTH(DEPTH), .CNT_OUT_W(CNT_OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_in      (rx_in),
  .rx_pin     (rx_pin),
  .rx_count   (rx_count),
  .trig_lvl   (trig_lvl),
  .full_flag  (full_flag),
  .full_clr   (full_clr),
  .ovr_flag   (ovr_flag),
  .brk_active (brk_active)
);

// File: tb/uart_rx_trig_test.sv
module uart_rx_trig_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick16, rx_in, par_en, par_odd, rd_en, full_clr, err_clr;
  logic [7:0] trig_lvl;
  logic [7:0] rd_data, rx_count;
  logic       full_flag, fer_flag, per_flag, ovr_flag, brk_active, rx_pin;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done = 0;
  bit  pop_on_push = 0;
  int  tdiv = 0;

  always #2 clk = ~clk;

  uart_rx_trig uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
    .par_en(par_en), .par_odd(par_odd), .trig_lvl(trig_lvl),
    .rd_en(rd_en), .rd_data(rd_data), .rx_count(rx_count),
    .full_clr(full_clr), .full_flag(full_flag), .err_clr(err_clr),
    .fer_flag(fer_flag), .per_flag(per_flag), .ovr_flag(ovr_flag),
    .brk_active(brk_active), .rx_pin(rx_pin)
  );

  // ---------------- behavioural reference ----------------
  byte unsigned q[$];
  int  m_s1, m_s2, m_st, m_ph, m_bit, m_sh, m_pacc, m_pbit, m_pbad;
  int  m_last, m_brk, m_hi;
  bit  m_push, m_fer_ev, m_per_ev;
  int  m_dat;
  bit  e_full, e_fer, e_per, e_ovr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_s1 = 1; m_s2 = 1; m_st = 0; m_ph = 0; m_bit = 0; m_sh = 0;
      m_pacc = 0; m_pbit = 0; m_pbad = 0; m_last = 1; m_brk = 0; m_hi = 0;
      m_push = 0; m_fer_ev = 0; m_per_ev = 0; m_dat = 0;
      e_full = 0; e_fer = 0; e_per = 0; e_ovr = 0;
    end else begin
      bit pop, lost, n_push, n_fer, n_per, centre, old_brk, brk_frame;
      int s, was_last, old_hi, n_dat;
      // flags and queue from the previous cycle's state
      e_full = (q.size() >= int'(trig_lvl)) || (e_full && !full_clr);
      pop  = rd_en && (q.size() > 0);
      lost = m_push && (q.size() == 16) && !pop;
      if (pop) void'(q.pop_front());
      if (m_push && !lost) q.push_back(byte'(m_dat));
      e_ovr = lost     || (e_ovr && !err_clr);
      e_fer = m_fer_ev || (e_fer && !err_clr);
      e_per = m_per_ev || (e_per && !err_clr);
      // line receiver
      n_push = 0; n_fer = 0; n_per = 0; n_dat = 0;
      if (tick16) begin
        s = m_s2; was_last = m_last; old_hi = m_hi; old_brk = m_brk[0];
        m_last = s;
        if (s != 0) begin if (m_hi < 16) m_hi++; end else m_hi = 0;
        if (old_brk && s != 0 && old_hi == 15) m_brk = 0;
        if (m_st == 0) begin
          if (was_last != 0 && s == 0) begin m_st = 1; m_ph = 0; end
        end else begin
          centre = (m_ph == 7);
          m_ph = (m_ph + 1) % 16;
          if (centre) begin
            case (m_st)
              1: if (s != 0) m_st = 0;
                 else begin m_st = 2; m_bit = 0; m_pacc = 0; m_pbit = 0; end
              2: begin
                m_sh = (m_sh >> 1) | (s << 7);
                m_pacc ^= s;
                if (m_bit == 7) m_st = par_en ? 3 : 4;
                m_bit++;
              end
              3: begin m_pbit = s; m_pbad = s ^ m_pacc ^ int'(par_odd); m_st = 4; end
              default: begin
                m_st = 0;
                brk_frame = (s == 0) && (m_sh == 0) && (!par_en || m_pbit == 0);
                n_fer  = (s == 0);
                n_per  = par_en && (m_pbad != 0);
                n_push = !old_brk && !brk_frame;
                n_dat  = m_sh;
                if (brk_frame) m_brk = 1;
              end
            endcase
          end
        end
      end
      m_push = n_push; m_fer_ev = n_fer; m_per_ev = n_per; m_dat = n_dat;
      m_s2 = m_s1; m_s1 = int'(rx_in);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R7 count", rx_count, q.size());
      check("R8 full_flag", full_flag, e_full);
      check("R5 fer_flag", fer_flag, e_fer);
      check("R4 per_flag", per_flag, e_per);
      check("R10 ovr_flag", ovr_flag, e_ovr);
      check("R12 brk_active", brk_active, m_brk);
      check("R14 rx_pin", rx_pin, m_s2);
      if (q.size() > 0) check("R6 rd_data", rd_data, q[0]);
    end
  end

  // tick generator and same-cycle pop driver
  always @(posedge clk) begin
    #1;
    tdiv   = (tdiv + 1) % 4;
    tick16 = (tdiv == 0);
    if (pop_on_push) rd_en = m_push;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive_bit(input logic v);
    rx_in = v;
    wait_clk(64);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input logic stop_v);
    logic p;
    p = (^d) ^ par_odd;
    if (bad_par) p = ~p;
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (par_en) drive_bit(p);
    drive_bit(stop_v);
    rx_in = 1'b1;
    wait_clk(24);
  endtask

  task automatic read_one();
    rd_en = 1'b1;
    wait_clk(1);
    rd_en = 1'b0;
    wait_clk(1);
  endtask

  task automatic pulse_full_clr();
    full_clr = 1'b1;
    wait_clk(1);
    full_clr = 1'b0;
  endtask

  task automatic pulse_err_clr();
    err_clr = 1'b1;
    wait_clk(1);
    err_clr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; rx_in = 1; tick16 = 0; rd_en = 0; full_clr = 0; err_clr = 0;
    par_en = 0; par_odd = 0; trig_lvl = 8'd4;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    wait_clk(8);
    @(negedge clk);
    check("R1 count", rx_count, 0);
    check("R1 full", full_flag, 0);
    check("R1 errors", {fer_flag, per_flag, ovr_flag}, 0);
    check("R1 break", brk_active, 0);
    wait_clk(1);

    // R3 / R8 / R9: four bytes reach trigger 4
    send_frame(8'hA5, 0, 1);
    send_frame(8'h3C, 0, 1);
    send_frame(8'hFF, 0, 1);
    @(negedge clk);
    check("R8 below trigger", full_flag, 0);
    wait_clk(1);
    send_frame(8'h81, 0, 1);
    @(negedge clk);
    check("R7 count four", rx_count, 4);
    check("R8 at trigger", full_flag, 1);
    wait_clk(1);
    pulse_full_clr();
    @(negedge clk);
    check("R9 clear ignored", full_flag, 1);
    check("R3 first byte", rd_data, 8'hA5);
    wait_clk(1);
    read_one();
    @(negedge clk);
    check("R8 sticky below", full_flag, 1);
    wait_clk(1);
    pulse_full_clr();
    @(negedge clk);
    check("R8 cleared", full_flag, 0);
    check("R3 second byte", rd_data, 8'h3C);
    wait_clk(1);
    read_one(); read_one();
    @(negedge clk);
    check("R3 last byte", rd_data, 8'h81);
    wait_clk(1);
    read_one();
    read_one();
    @(negedge clk);
    check("R6 empty read", rx_count, 0);
    wait_clk(1);

    // R2: false start shorter than half a bit
    rx_in = 0; wait_clk(12); rx_in = 1; wait_clk(200);
    @(negedge clk);
    check("R2 false start", rx_count, 0);
    wait_clk(1);

    // R4: parity, even then odd
    par_en = 1; par_odd = 0;
    send_frame(8'h31, 0, 1);
    @(negedge clk);
    check("R4 even good", per_flag, 0);
    wait_clk(1);
    send_frame(8'h32, 1, 1);
    @(negedge clk);
    check("R4 even bad", per_flag, 1);
    wait_clk(1);
    pulse_err_clr();
    par_odd = 1;
    send_frame(8'h07, 0, 1);
    @(negedge clk);
    check("R4 odd good", per_flag, 0);
    wait_clk(1);
    send_frame(8'h07, 1, 1);
    @(negedge clk);
    check("R4 odd bad", per_flag, 1);
    wait_clk(1);
    par_en = 0; par_odd = 0;
    pulse_err_clr();

    // R5: framing error with data, still stored
    send_frame(8'h5A, 0, 0);
    @(negedge clk);
    check("R5 fer set", fer_flag, 1);
    check("R5 stored", rx_count, 5);
    wait_clk(1);
    pulse_err_clr();
    @(negedge clk);
    check("R5 fer cleared", fer_flag, 0);
    wait_clk(1);
    for (int i = 0; i < 5; i++) read_one();

    // R10: overrun
    trig_lvl = 8'd16;
    for (int i = 0; i < 17; i++) send_frame(8'h10 + 8'(i), 0, 1);
    @(negedge clk);
    check("R10 count held", rx_count, 16);
    check("R10 ovr set", ovr_flag, 1);
    wait_clk(1);
    pulse_err_clr();

    // R11: write and pop in one cycle on a full queue
    pop_on_push = 1;
    send_frame(8'h77, 0, 1);
    pop_on_push = 0;
    rd_en = 0;
    @(negedge clk);
    check("R11 count", rx_count, 16);
    check("R11 no ovr", ovr_flag, 0);
    check("R6 head order", rd_data, 8'h11);
    wait_clk(1);
    for (int i = 0; i < 16; i++) read_one();
    @(negedge clk);
    check("R6 drained", rx_count, 0);
    check("R8 still set", full_flag, 1);
    wait_clk(1);
    pulse_full_clr();

    // R12 / R13: break, frame inside break, recovery
    rx_in = 0; wait_clk(12 * 64);
    @(negedge clk);
    check("R12 brk", brk_active, 1);
    check("R12 fer", fer_flag, 1);
    check("R12 not stored", rx_count, 0);
    wait_clk(1);
    rx_in = 1; wait_clk(32);
    send_frame(8'h00, 0, 1);
    @(negedge clk);
    check("R12 suppressed", rx_count, 0);
    check("R13 brk over", brk_active, 0);
    wait_clk(1);
    send_frame(8'h66, 0, 1);
    @(negedge clk);
    check("R13 resumed", rx_count, 1);
    check("R13 data", rd_data, 8'h66);
    wait_clk(4);
    finish_run();
  end
endmodule